// File: doc/BRIEF.md
# BCD Real-Time Clock Register Bank

This block keeps time of day and calendar in eight byte-wide registers. Seven of them hold the time and date fields as packed BCD: seconds, minutes, hours, date, month, day of week and year. The eighth is a control register that holds a write-lock flag. An internal prescaler divides the input clock (nominally 32768 Hz) into a one-cycle tick per second. Each tick moves the seconds forward, and carries ripple up through minutes, hours, date, month and year.

A serial front end drives the block through a plain parallel port. It has a write strobe with an address, a data byte and a flag that marks the write as part of a burst. A separate combinational read address returns any register. The seconds register carries a halt flag that freezes counting. The hours register selects between 12-hour and 24-hour presentation, and its bit 5 has a different meaning in each mode.

Top module: `rtc_bcd_bank`

## Requirements
- R1: After reset the registers read as follows. Address 0 (seconds) reads 0x80, which is halted. Address 1 (minutes) reads 0x00 and address 2 (hours) reads 0x00. Address 3 (date), address 4 (month) and address 5 (day of week) each read 0x01. Address 6 (year) reads 0x00 and address 7 (control) reads 0x00.
- R2: While counting runs, `sec_tick` is high for exactly one cycle in every PRESCALE cycles. Each such cycle advances the seconds at the following clock edge.
- R3: Seconds bit 7 is the halt flag. While it is 1, no tick occurs and no time register changes. Writing it to 0 resumes counting.
- R4: The seconds field (bits 6:0) and the minutes field (bits 6:0) count in BCD from 00 to 59. On wrap to 00, each carries into the next field.
- R5: When hours bit 7 is 0 (24-hour mode), bits 5:0 count in BCD from 00 to 23, and bit 5 is the tens bit for hours 20 to 23. Going from 23 to 00 carries into the date.
- R6: When hours bit 7 is 1 (12-hour mode), bits 4:0 hold 01 to 12 in BCD and bit 5 is the PM flag (1 = PM). Going from 11 to 12 toggles the flag, and 12 goes to 01. Going from 11 PM to 12 AM carries into the date.
- R7: The date counts in BCD from 01 up to the length of the month and then returns to 01, incrementing the month. Months 04, 06, 09 and 11 have 30 days, month 02 has 29 days when the year value is divisible by 4 and 28 otherwise, and all other months have 31. The day of week counts 1 to 7 and goes from 7 back to 1 on each date carry.
- R8: The month goes from 12 to 01 and increments the year. The year goes from 99 to 00.
- R9: While control bit 7 (write lock) is 1, writes to addresses 0 to 6 have no effect. While it is 0, both single and burst writes to those addresses are stored.
- R10: A single write (`acc_burst` = 0) to address 7 always loads control bit 7 from data bit 7, even while the lock is set. A burst write to address 7 is ignored.
- R11: A write that is stored into any of addresses 0 to 6 restarts the prescaler, so the next tick comes PRESCALE cycles after that write.
- R12: `acc_rdata` shows, in the same cycle, the register selected by `acc_raddr`. Control bits 6:0 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock (nominally 32768 Hz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_wr | input | 1 | Register write strobe |
| acc_burst | input | 1 | Marks the write as part of a burst transfer |
| acc_addr | input | 3 | Write address (0 sec, 1 min, 2 hour, 3 date, 4 month, 5 weekday, 6 year, 7 control) |
| acc_wdata | input | 8 | Write data |
| acc_raddr | input | 3 | Read address, same map as the write address |
| acc_rdata | output | 8 | Read data for the selected register |
| sec_tick | output | 1 | One-cycle pulse, one per second |

## Verification
Directed loads place the clock just before each rollover boundary and check the values after the step against constants. The boundaries are 23:59:59 into a leap and a non-leap February, 11:59:59 PM on the last day of year 99, 12:59 AM, 11:59 AM and 30-day month ends. This separates the month-length rules and the PM toggle from a plain increment. Random valid times in both hour modes, advanced by random tick counts, are compared with a bench model that converts to binary. The model catches wrong carries that only show up after several cascaded steps. Timing is probed by sampling `sec_tick` one cycle before the expected step and by rewriting mid-period. This tells a prescaler that restarts on a write apart from one that runs freely. Lock, burst and halt stimuli are each followed by reads that would show any change they made.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   localparam int REG_W    = 8;
   localparam int ADDR_W   = 3;
   localparam int NUM_TIME = 7;
   localparam int NUM_REG  = NUM_TIME + 1;

   typedef enum logic [ADDR_W-1:0] {
      RA_SEC  = 3'd0,
      RA_MIN  = 3'd1,
      RA_HOUR = 3'd2,
      RA_DATE = 3'd3,
      RA_MON  = 3'd4,
      RA_DOW  = 3'd5,
      RA_YEAR = 3'd6,
      RA_CTRL = 3'd7
   } rtc_addr_e;

   // next BCD value of a two-digit field, no wrap handling
   function automatic logic [REG_W-1:0] bcd_inc(input logic [REG_W-1:0] v);
      logic [REG_W-1:0] r;
      if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
      else                r = {v[7:4], v[3:0] + 4'd1};
      return r;
   endfunction

   function automatic logic [6:0] bcd_bin(input logic [REG_W-1:0] v);
      return 7'({3'b000, v[7:4]}) * 7'd10 + 7'({3'b000, v[3:0]});
   endfunction

   // last date of a month, returned in BCD
   function automatic logic [REG_W-1:0] month_len(input logic [REG_W-1:0] mon,
                                                  input logic [REG_W-1:0] yr);
      logic [6:0] m;
      logic [6:0] y;
      logic [REG_W-1:0] r;
      m = bcd_bin(mon);
      y = bcd_bin(yr);
      case (m)
         7'd2:                    r = (y[1:0] == 2'b00) ? 8'h29 : 8'h28;
         7'd4, 7'd6, 7'd9, 7'd11: r = 8'h30;
         default:                 r = 8'h31;
      endcase
      return r;
   endfunction

   function automatic logic [REG_W-1:0] reset_value(input int idx);
      logic [REG_W-1:0] r;
      case (idx)
         0:       r = 8'h80;
         3, 4, 5: r = 8'h01;
         default: r = 8'h00;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int PRESCALE = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clear,
   output logic tick
);
   localparam int CW   = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
   localparam bit POW2 = ((1 << CW) == PRESCALE);
   localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

   logic [CW-1:0] cnt;

   if (PRESCALE < 2) begin : g_bad_prescale
      $error("rtc_prescaler: PRESCALE must be at least 2");
   end

   if (POW2) begin : g_pow2
      // natural wrap of the counter gives the period
      assign tick = run && !clear && (&cnt);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     cnt <= '0;
         else if (clear) cnt <= '0;
         else if (run)   cnt <= cnt + 1'b1;
      end
   end else begin : g_modulo
      assign tick = run && !clear && (cnt == LAST);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     cnt <= '0;
         else if (clear) cnt <= '0;
         else if (run)   cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
   end

endmodule

// File: rtl/rtc_clock_chain.sv
module rtc_clock_chain
   import rtc_pkg::*;
(
   input  logic             step,
   input  logic [REG_W-1:0] sec_q,
   input  logic [REG_W-1:0] min_q,
   input  logic [REG_W-1:0] hour_q,
   output logic [REG_W-1:0] sec_d,
   output logic [REG_W-1:0] min_d,
   output logic [REG_W-1:0] hour_d,
   output logic             day_carry
);
   logic [REG_W-1:0] sec_inc, min_inc, h12, h12_inc, h24, h24_inc;
   logic             pm;

   always_comb begin
      sec_inc = bcd_inc({1'b0, sec_q[6:0]});
      min_inc = bcd_inc({1'b0, min_q[6:0]});
      h12     = {3'b000, hour_q[4:0]};
      h12_inc = bcd_inc(h12);
      h24     = {2'b00, hour_q[5:0]};
      h24_inc = bcd_inc(h24);
      pm      = hour_q[5];

      sec_d     = sec_q;
      min_d     = min_q;
      hour_d    = hour_q;
      day_carry = 1'b0;

      if (step) begin
         if (sec_q[6:0] != 7'h59) begin
            sec_d = {1'b0, sec_inc[6:0]};
         end else begin
            sec_d = 8'h00;
            if (min_q[6:0] != 7'h59) begin
               min_d = {1'b0, min_inc[6:0]};
            end else begin
               min_d = 8'h00;
               if (hour_q[7]) begin
                  if (h12 == 8'h12) begin
                     hour_d = {2'b10, pm, 5'h01};
                  end else if (h12 == 8'h11) begin
                     hour_d    = {2'b10, ~pm, 5'h12};
                     day_carry = pm;
                  end else begin
                     hour_d = {2'b10, pm, h12_inc[4:0]};
                  end
               end else begin
                  if (h24 == 8'h23) begin
                     hour_d    = 8'h00;
                     day_carry = 1'b1;
                  end else begin
                     hour_d = {2'b00, h24_inc[5:0]};
                  end
               end
            end
         end
      end
   end

endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
   import rtc_pkg::*;
(
   input  logic             step,
   input  logic [REG_W-1:0] date_q,
   input  logic [REG_W-1:0] mon_q,
   input  logic [REG_W-1:0] dow_q,
   input  logic [REG_W-1:0] year_q,
   output logic [REG_W-1:0] date_d,
   output logic [REG_W-1:0] mon_d,
   output logic [REG_W-1:0] dow_d,
   output logic [REG_W-1:0] year_d
);
   logic [REG_W-1:0] last_day, date_inc, mon_inc, year_inc;

   always_comb begin
      last_day = month_len(mon_q, year_q);
      date_inc = bcd_inc({2'b00, date_q[5:0]});
      mon_inc  = bcd_inc({3'b000, mon_q[4:0]});
      year_inc = bcd_inc(year_q);

      date_d = date_q;
      mon_d  = mon_q;
      dow_d  = dow_q;
      year_d = year_q;

      if (step) begin
         dow_d = (dow_q[2:0] == 3'd7) ? 8'h01 : {5'b00000, dow_q[2:0] + 3'd1};
         if ({2'b00, date_q[5:0]} != last_day) begin
            date_d = {2'b00, date_inc[5:0]};
         end else begin
            date_d = 8'h01;
            if (mon_q[4:0] != 5'h12) begin
               mon_d = {3'b000, mon_inc[4:0]};
            end else begin
               mon_d  = 8'h01;
               year_d = (year_q == 8'h99) ? 8'h00 : year_inc;
            end
         end
      end
   end

endmodule

// File: rtl/rtc_bcd_bank.sv
module rtc_bcd_bank
   import rtc_pkg::*;
#(
   parameter int PRESCALE = 32768
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_wr,
   input  logic              acc_burst,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [REG_W-1:0]  acc_wdata,
   input  logic [ADDR_W-1:0] acc_raddr,
   output logic [REG_W-1:0]  acc_rdata,
   output logic              sec_tick
);
   localparam int FLAT_W = NUM_TIME * REG_W;

   if (NUM_REG != (1 << ADDR_W)) begin : g_bad_map
      $error("rtc_bcd_bank: register map must fill the address space");
   end

   logic [REG_W-1:0]  tr_q [NUM_TIME];
   logic [REG_W-1:0]  adv  [NUM_TIME];
   logic [REG_W-1:0]  rd_bank [NUM_REG];
   logic [FLAT_W-1:0] time_flat;
   logic              wp_q;
   logic              wr_ok, time_wr, ctrl_wr, run;
   logic              day_carry;

   assign wr_ok   = acc_wr && !wp_q;
   assign time_wr = wr_ok && (acc_addr != RA_CTRL);
   assign ctrl_wr = acc_wr && !acc_burst && (acc_addr == RA_CTRL);
   assign run     = !tr_q[RA_SEC][7];

   rtc_prescaler #(.PRESCALE(PRESCALE)) i_prescaler (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .clear (time_wr),
      .tick  (sec_tick)
   );

   rtc_clock_chain i_clock_chain (
      .step      (sec_tick),
      .sec_q     (tr_q[RA_SEC]),
      .min_q     (tr_q[RA_MIN]),
      .hour_q    (tr_q[RA_HOUR]),
      .sec_d     (adv[RA_SEC]),
      .min_d     (adv[RA_MIN]),
      .hour_d    (adv[RA_HOUR]),
      .day_carry (day_carry)
   );

   rtc_date_chain i_date_chain (
      .step   (day_carry),
      .date_q (tr_q[RA_DATE]),
      .mon_q  (tr_q[RA_MON]),
      .dow_q  (tr_q[RA_DOW]),
      .year_q (tr_q[RA_YEAR]),
      .date_d (adv[RA_DATE]),
      .mon_d  (adv[RA_MON]),
      .dow_d  (adv[RA_DOW]),
      .year_d (adv[RA_YEAR])
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_TIME; i++) tr_q[i] <= reset_value(i);
      end else begin
         for (int i = 0; i < NUM_TIME; i++) begin
            if (time_wr && (acc_addr == ADDR_W'(i))) tr_q[i] <= acc_wdata;
            else if (sec_tick)                        tr_q[i] <= adv[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       wp_q <= 1'b0;
      else if (ctrl_wr) wp_q <= acc_wdata[7];
   end

   for (genvar g = 0; g < NUM_REG; g++) begin : g_rd
      if (g < NUM_TIME) begin : g_time
         assign rd_bank[g] = tr_q[g];
         assign time_flat[g*REG_W +: REG_W] = tr_q[g];
      end else begin : g_ctrl
         assign rd_bank[g] = {wp_q, 7'b0000000};
      end
   end

   assign acc_rdata = rd_bank[acc_raddr];

endmodule

// File: rtl/rtc_bcd_bank_chk.sv
module rtc_bcd_bank_chk #(
   parameter int FLAT_W = 56
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_wr,
   input logic              acc_burst,
   input logic [2:0]        acc_addr,
   input logic              sec_tick,
   input logic              wp_q,
   input logic [7:0]        sec_q,
   input logic [FLAT_W-1:0] time_flat
);

   assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> !sec_tick);

   assert_halt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_q[7] && !acc_wr) |=> $stable(time_flat));

   assert_sec_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && sec_q[6:0] == 7'h59) |=> (sec_q[6:0] == 7'h00));

   assert_lock_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wp_q && !sec_tick) |=> $stable(time_flat));

   assert_burst_ctrl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && acc_burst && acc_addr == 3'd7) |=> $stable(wp_q));

   assert_write_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && !wp_q && acc_addr != 3'd7) |=> !sec_tick);

endmodule

bind rtc_bcd_bank rtc_bcd_bank_chk #(.FLAT_W(FLAT_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_wr    (acc_wr),
   .acc_burst (acc_burst),
   .acc_addr  (acc_addr),
   .sec_tick  (sec_tick),
   .wp_q      (wp_q),
   .sec_q     (tr_q[0]),
   .time_flat (time_flat)
);

// File: tb/test_rtc_bcd_bank.sv
module test_rtc_bcd_bank;
   localparam int P = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_wr = 1'b0, acc_burst = 1'b0;
   logic [2:0] acc_addr = '0, acc_raddr = '0;
   logic [7:0] acc_wdata = '0;
   logic [7:0] acc_rdata;
   logic       sec_tick;

   int checks = 0, fails = 0, ticks = 0;

   always #4 clk = ~clk;

   rtc_bcd_bank #(.PRESCALE(P)) i_rtc_bcd_bank (
      .clk, .rst_n, .acc_wr, .acc_burst, .acc_addr, .acc_wdata,
      .acc_raddr, .acc_rdata, .sec_tick
   );

   always @(negedge clk) if (rst_n && sec_tick) ticks++;

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic burst);
      @(negedge clk);
      acc_wr = 1'b1; acc_addr = a; acc_wdata = d; acc_burst = burst;
      @(posedge clk);
      @(negedge clk);
      acc_wr = 1'b0; acc_burst = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      acc_raddr = a;
      #1;
      d = acc_rdata;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   function automatic int b2i(input logic [7:0] b);
      return int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction

   function automatic logic [7:0] i2b(input int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic int dim(input int mo, input int y);
      if (mo == 2) return (y % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   // time word: byte i holds register i
   function automatic logic [55:0] model_step(input logic [55:0] t);
      int s, m, h, d, mo, y, w, hh;
      bit mode12, pm, day;
      logic [7:0] hb;
      logic [55:0] r;
      s = b2i(t[7:0] & 8'h7f) + 1;
      m = b2i(t[15:8] & 8'h7f);
      hb = t[23:16];
      mode12 = hb[7];
      h = mode12 ? (b2i(hb & 8'h1f) % 12) + (hb[5] ? 12 : 0) : b2i(hb & 8'h3f);
      d = b2i(t[31:24]); mo = b2i(t[39:32]); w = int'(t[42:40]); y = b2i(t[55:48]);
      day = 1'b0;
      if (s == 60) begin
         s = 0; m++;
         if (m == 60) begin
            m = 0; h++;
            if (h == 24) begin h = 0; day = 1'b1; end
         end
      end
      if (day) begin
         w = (w == 7) ? 1 : w + 1;
         d++;
         if (d > dim(mo, y)) begin
            d = 1; mo++;
            if (mo > 12) begin mo = 1; y = (y + 1) % 100; end
         end
      end
      r[7:0] = i2b(s); r[15:8] = i2b(m);
      if (mode12) begin
         pm = (h >= 12); hh = h % 12; if (hh == 0) hh = 12;
         r[23:16] = 8'h80 | (8'(pm) << 5) | i2b(hh);
      end else r[23:16] = i2b(h);
      r[31:24] = i2b(d); r[39:32] = i2b(mo); r[47:40] = 8'(w); r[55:48] = i2b(y);
      return r;
   endfunction

   task automatic load(input logic [55:0] t);
      for (int i = 1; i < 7; i++) wr(3'(i), t[i*8 +: 8], 1'b0);
      wr(3'd0, t[7:0], 1'b0);
   endtask

   task automatic check_all(input string req, input logic [55:0] exp);
      logic [7:0] v;
      for (int i = 0; i < 7; i++) begin
         rd(3'(i), v);
         check(req, v, exp[i*8 +: 8]);
      end
   endtask

   task automatic run_case(input string req, input logic [55:0] t, input int k,
                           output logic [55:0] exp);
      exp = t;
      for (int i = 0; i < k; i++) exp = model_step(exp);
      load(t);
      wait_cyc(k * P);
      check_all(req, exp);
   endtask

   function automatic logic [55:0] tw(input logic [7:0] y, dw, mo, d, h, m, s);
      return {y, dw, mo, d, h, m, s};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] v;
      logic [55:0] e;
      int t0;
      void'($urandom(32'd20251));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset contents
      check_all("R1", tw(8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h80));
      rd(3'd7, v); check("R1 control", v, 8'h00);

      // R3 halted out of reset
      wait_cyc(3 * P);
      rd(3'd0, v); check("R3 halted after reset", v, 8'h80);
      check("R3 no tick while halted", 8'(ticks), 8'd0);

      // R2 / R11 tick timing
      load(tw(8'h10, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h10));
      wait_cyc(P - 1);
      rd(3'd0, v); check("R11 no step before period", v, 8'h10);
      check("R2 tick one cycle before step", 8'(sec_tick), 8'd1);
      wait_cyc(1);
      rd(3'd0, v); check("R2 step", v, 8'h11);
      check("R2 tick is one cycle", 8'(sec_tick), 8'd0);
      t0 = ticks;
      wait_cyc(5 * P);
      check("R2 tick count per period", 8'(ticks - t0), 8'd5);
      wait_cyc(P / 2);
      wr(3'd0, 8'h30, 1'b0);
      wait_cyc(P - 1);
      rd(3'd0, v); check("R11 rewrite restarts period", v, 8'h30);
      wait_cyc(1);
      rd(3'd0, v); check("R11 step after full period", v, 8'h31);

      // R3 halt and restart
      wr(3'd0, 8'h85, 1'b0);
      t0 = ticks;
      wait_cyc(4 * P);
      rd(3'd0, v); check("R3 held", v, 8'h85);
      rd(3'd1, v); check("R3 minutes held", v, 8'h06);
      check("R3 no ticks", 8'(ticks - t0), 8'd0);
      wr(3'd0, 8'h05, 1'b0);
      wait_cyc(P);
      rd(3'd0, v); check("R3 restart", v, 8'h06);

      // directed rollovers with explicit expected values
      run_case("R5 R7 leap Feb", tw(8'h24, 8'h07, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59), 1, e);
      check("R7 leap date", e[31:24], 8'h29); check("R7 dow wrap", e[47:40], 8'h01);
      check("R5 hour wrap", e[23:16], 8'h00);
      run_case("R7 non-leap Feb", tw(8'h23, 8'h03, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59), 1, e);
      check("R7 march", e[39:32], 8'h03); check("R7 first", e[31:24], 8'h01);
      run_case("R8 year end 12h", tw(8'h99, 8'h06, 8'h12, 8'h31, 8'hB1, 8'h59, 8'h59), 1, e);
      check("R8 year wrap", e[55:48], 8'h00); check("R6 12 AM", e[23:16], 8'h92);
      check("R8 month wrap", e[39:32], 8'h01);
      run_case("R6 12 to 1", tw(8'h05, 8'h01, 8'h01, 8'h10, 8'h92, 8'h59, 8'h59), 1, e);
      check("R6 one AM", e[23:16], 8'h81);
      run_case("R6 noon", tw(8'h05, 8'h01, 8'h01, 8'h10, 8'h91, 8'h59, 8'h59), 1, e);
      check("R6 PM set", e[23:16], 8'hB2); check("R6 no date carry", e[31:24], 8'h10);
      run_case("R7 30-day month", tw(8'h05, 8'h02, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59), 1, e);
      check("R7 May 1", e[39:32], 8'h05);
      run_case("R5 tens bit", tw(8'h05, 8'h02, 8'h04, 8'h01, 8'h19, 8'h59, 8'h58), 2, e);
      check("R5 twenty", e[23:16], 8'h20); check("R4 min wrap", e[15:8], 8'h00);

      // R9 / R10 / R12 lock behaviour
      load(tw(8'h05, 8'h02, 8'h04, 8'h01, 8'h10, 8'h20, 8'h00));
      wr(3'd7, 8'h80, 1'b0);
      rd(3'd7, v); check("R10 lock set by single write", v, 8'h80);
      wr(3'd1, 8'h42, 1'b0);
      rd(3'd1, v); check("R9 locked write ignored", v, 8'h20);
      wr(3'd6, 8'h77, 1'b1);
      rd(3'd6, v); check("R9 locked burst ignored", v, 8'h05);
      wr(3'd7, 8'h00, 1'b1);
      rd(3'd7, v); check("R10 burst cannot clear lock", v, 8'h80);
      wr(3'd7, 8'h00, 1'b0);
      rd(3'd7, v); check("R10 single write clears lock", v, 8'h00);
      wr(3'd7, 8'h80, 1'b1);
      rd(3'd7, v); check("R10 burst cannot set lock", v, 8'h00);
      wr(3'd1, 8'h33, 1'b1);
      rd(3'd1, v); check("R9 burst accepted when unlocked", v, 8'h33);
      wr(3'd7, 8'h7F, 1'b0);
      rd(3'd7, v); check("R12 control low bits zero", v, 8'h00);

      // random valid times in both modes
      for (int n = 0; n < 25; n++) begin
         int mo, y, hr, k;
         logic [7:0] hb;
         mo = $urandom_range(1, 12);
         y  = $urandom_range(0, 99);
         hr = $urandom_range(0, 23);
         if ($urandom_range(0, 1) == 1) begin
            int hh;
            hh = hr % 12; if (hh == 0) hh = 12;
            hb = 8'h80 | (8'(hr >= 12) << 5) | i2b(hh);
         end else hb = i2b(hr);
         k = $urandom_range(1, 40);
         run_case("R4/R5/R6/R7 random",
                  tw(i2b(y), 8'($urandom_range(1, 7)), i2b(mo),
                     i2b(($urandom_range(0, 1) == 1) ? dim(mo, y) : $urandom_range(1, dim(mo, y))),
                     ($urandom_range(0, 1) == 1) ? i2b(($urandom_range(0, 1) == 1) ? 23 : 11) | (hb & 8'h80) | ((hb[7]) ? 8'h20 : 8'h00) : hb,
                     ($urandom_range(0, 1) == 1) ? 8'h59 : i2b($urandom_range(0, 59)),
                     i2b($urandom_range(30, 59))),
                  k, e);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule